// File: doc/BRIEF.md
# Dual-Mode DRAM Access Start Sequencer

This block opens and closes the row strobe for processor accesses to DRAM on a single port. A processor announces an access by raising a strobe while its chip select is active. A mode input picks between two ways of starting. In latched mode, the strobe arms an internal pending flag, and the row strobe rises on a later clock edge. In strobe mode, the row strobe follows the strobe combinationally as soon as the controller is idle and nothing else holds it busy.

Once an access is running, the access-request input controls how long it lasts. The row strobe stays up until the request has been seen high and is then sampled low. A `busy_i` input stands for any other controller activity, such as refresh. While it is high, no access can begin, and a request is kept pending until the controller is free.

A falling edge of the strobe, sampled on the clock, produces a one-cycle address-latch pulse when latching is enabled. A strobe that stays high after an access ends cannot start a second access. The strobe must be sampled low first.

Top module: `dram_access_seq`

## Requirements
- R1: A synchronous high `rst_i` forces `ras_o`, `acc_active_o` and `alatch_o` low by the first edge that samples it, including in the middle of an access.
- R2: A strobe sampled without chip select starts nothing: `acc_active_o` and `ras_o` stay low.
- R3: With `mode_i`=0, an edge that samples `cs_i`=1 and `strobe_i`=1 while idle raises `acc_active_o` with `ras_o` still low. `ras_o` rises after the next edge that samples `busy_i`=0. In this mode `ras_o` is never high while `acc_active_o` is low.
- R4: A pending access stays pending, with `ras_o` low, for as long as `busy_i` is sampled high.
- R5: With `mode_i`=1, while idle and re-armed, `ras_o` goes high within the same cycle that `cs_i`, `strobe_i` and `!busy_i` all hold, before any clock edge. The edge that samples this condition makes the access active.
- R6: With `mode_i`=1 and `busy_i` high, a start is held pending with `ras_o` low. `ras_o` rises after the first edge that samples `busy_i`=0.
- R7: Once `areq_i` has been sampled high during the row strobe, the first edge that samples `areq_i` low drops `ras_o` and `acc_active_o`.
- R8: After an access has started, a new access needs `strobe_i` to be sampled low first. A strobe held high across the end of an access does not restart it.
- R9: When `lat_en_i`=1, `alatch_o` is high for exactly the one cycle that follows an edge sampling `strobe_i` low after an edge sampling it high. When `lat_en_i`=0, `alatch_o` stays low.
- R10: `areq_i` low during the row strobe does not end the access until `areq_i` has been sampled high at least once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| cs_i | input | 1 | Chip select, qualifies the strobe |
| strobe_i | input | 1 | Access strobe (latch enable in mode 0, address strobe in mode 1) |
| areq_i | input | 1 | Access request; its release ends the access |
| mode_i | input | 1 | 0 = latched start, 1 = strobe start |
| busy_i | input | 1 | Another controller event is in progress |
| lat_en_i | input | 1 | Enables the address-latch pulse |
| ras_o | output | 1 | Row strobe for the processor access |
| acc_active_o | output | 1 | Access pending or running (registered) |
| alatch_o | output | 1 | One-cycle address capture pulse (registered) |

## Verification
The access flag and the address-latch pulse are registered, so each is due one edge after the inputs that cause it. The latched-mode row strobe is due two edges after the strobe, or one edge after `busy_i` is sampled low. The bench drives each vector just after a rising edge, waits for the next edge, and samples one time unit later, so every registered result is checked exactly one edge after its cause. The combinational strobe-mode start is checked a unit after the inputs change and before any edge, which proves that it does not wait for the clock.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PEND = 2'd1,
    SQ_ROW  = 2'd2
  } sq_state_e;

endpackage

// File: rtl/strobe_capture.sv
module strobe_capture (
  input  logic clk_i,
  input  logic rst_i,
  input  logic strobe_i,
  input  logic lat_en_i,
  input  logic start_i,
  output logic rearm_o,
  output logic alatch_o
);

  logic stb_q;
  logic rearm_q;
  logic alatch_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stb_q    <= 1'b0;
      rearm_q  <= 1'b1;
      alatch_q <= 1'b0;
    end else begin
      stb_q    <= strobe_i;
      alatch_q <= lat_en_i & stb_q & ~strobe_i;
      if (start_i)
        rearm_q <= 1'b0;
      else if (!strobe_i)
        rearm_q <= 1'b1;
    end
  end

  assign rearm_o  = rearm_q;
  assign alatch_o = alatch_q;

  // R9: the capture pulse never lasts more than one cycle
  assert_alatch_single_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    alatch_q |=> !alatch_q);

  // R9: no pulse while latching is disabled
  assert_alatch_gated_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !lat_en_i |=> !alatch_q);

endmodule

// File: rtl/access_fsm.sv
module access_fsm
  import dram_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic cs_i,
  input  logic strobe_i,
  input  logic areq_i,
  input  logic mode_i,
  input  logic busy_i,
  input  logic rearm_i,
  output logic start_o,
  output logic idle_o,
  output logic row_o
);

  sq_state_e st_q, st_d;
  logic      seen_q;
  logic      go;

  assign go      = cs_i & strobe_i & rearm_i;
  assign start_o = (st_q == SQ_IDLE) & go;

  always_comb begin
    st_d = st_q;
    case (st_q)
      SQ_IDLE: if (go) st_d = (mode_i && !busy_i) ? SQ_ROW : SQ_PEND;
      SQ_PEND: if (!busy_i) st_d = SQ_ROW;
      SQ_ROW:  if (seen_q && !areq_i) st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q   <= SQ_IDLE;
      seen_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q != SQ_ROW || st_d != SQ_ROW)
        seen_q <= 1'b0;
      else if (areq_i)
        seen_q <= 1'b1;
    end
  end

  assign idle_o = (st_q == SQ_IDLE);
  assign row_o  = (st_q == SQ_ROW);

  // R2: no chip select together with the strobe, no departure from idle
  assert_no_start_without_cs_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == SQ_IDLE && !(cs_i && strobe_i)) |=> st_q == SQ_IDLE);

  // R4: a pending access waits out the busy event
  assert_pend_holds_busy_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == SQ_PEND && busy_i) |=> st_q == SQ_PEND);

  // R7: request released after being seen ends the row strobe
  assert_end_on_release_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == SQ_ROW && seen_q && !areq_i) |=> st_q == SQ_IDLE);

  // R8: no new start before the strobe is seen low
  assert_rearm_needed_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == SQ_IDLE && !rearm_i) |=> st_q == SQ_IDLE);

  // R10: the row strobe never ends before the request is seen high
  assert_hold_until_seen_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == SQ_ROW && !seen_q) |=> st_q == SQ_ROW);

endmodule

// File: rtl/ras_gate.sv
module ras_gate (
  input  logic rst_i,
  input  logic row_i,
  input  logic idle_i,
  input  logic rearm_i,
  input  logic mode_i,
  input  logic cs_i,
  input  logic strobe_i,
  input  logic busy_i,
  output logic ras_o
);

  logic early;

  assign early = mode_i & idle_i & rearm_i & cs_i & strobe_i & ~busy_i;
  assign ras_o = ~rst_i & (row_i | early);

endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq (
  input  logic clk_i,
  input  logic rst_i,
  input  logic cs_i,
  input  logic strobe_i,
  input  logic areq_i,
  input  logic mode_i,
  input  logic busy_i,
  input  logic lat_en_i,
  output logic ras_o,
  output logic acc_active_o,
  output logic alatch_o
);

  logic start_w;
  logic rearm_w;
  logic idle_w;
  logic row_w;

  strobe_capture u_cap (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .strobe_i (strobe_i),
    .lat_en_i (lat_en_i),
    .start_i  (start_w),
    .rearm_o  (rearm_w),
    .alatch_o (alatch_o)
  );

  access_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .cs_i     (cs_i),
    .strobe_i (strobe_i),
    .areq_i   (areq_i),
    .mode_i   (mode_i),
    .busy_i   (busy_i),
    .rearm_i  (rearm_w),
    .start_o  (start_w),
    .idle_o   (idle_w),
    .row_o    (row_w)
  );

  ras_gate u_gate (
    .rst_i    (rst_i),
    .row_i    (row_w),
    .idle_i   (idle_w),
    .rearm_i  (rearm_w),
    .mode_i   (mode_i),
    .cs_i     (cs_i),
    .strobe_i (strobe_i),
    .busy_i   (busy_i),
    .ras_o    (ras_o)
  );

  assign acc_active_o = ~idle_w;

  // R3: latched mode never drives the row strobe from idle
  assert_mode0_sync_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!mode_i && !acc_active_o) |-> !ras_o);

  // R6: an early row strobe never appears while another event is busy
  assert_busy_blocks_early_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_i && !acc_active_o) |-> !ras_o);

endmodule

// File: tb/sim_dram_access_seq.sv
module sim_dram_access_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;

  // row: {cs, strobe, areq, mode, busy, lat_en, exp_ras, exp_act, exp_alatch}
  localparam logic [8:0] VEC [NVEC] = '{
    9'b010001_000, // 0  R2 strobe without cs
    9'b000001_001, // 1  R9 sampled fall -> pulse
    9'b110001_010, // 2  R3 mode0 start -> pending
    9'b110011_010, // 3  R4 busy holds pending
    9'b111001_110, // 4  R3 row strobe up
    9'b101001_111, // 5  R9 fall during access
    9'b001001_110, // 6
    9'b000001_000, // 7  R7 release ends access
    9'b110001_010, // 8  R3 new pending
    9'b110001_110, // 9  row up, areq low
    9'b110001_110, // 10 R10 areq never seen -> hold
    9'b111001_110, // 11 seen
    9'b110001_000, // 12 R7 end
    9'b110001_000, // 13 R8 strobe still high, no restart
    9'b000001_001, // 14 R9 fall -> rearm
    9'b110111_010, // 15 R6 mode1 busy -> pending
    9'b111111_010, // 16 R6 still busy
    9'b111101_110, // 17 R6 free -> row up
    9'b101101_111, // 18 seen, fall pulse
    9'b100101_000, // 19 R7 end
    9'b111101_110, // 20 R5 mode1 start
    9'b100101_111, // 21 R10 hold, fall pulse
    9'b001101_110, // 22 seen
    9'b000100_000, // 23 R7 end
    9'b010100_000, // 24 latching off
    9'b000100_000  // 25 R9 no pulse when disabled
  };

  logic clk = 1'b0;
  logic rst, cs, strobe, areq, mode, busy, lat_en;
  logic ras, act, alat;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dram_access_seq u0 (
    .clk_i(clk), .rst_i(rst), .cs_i(cs), .strobe_i(strobe), .areq_i(areq),
    .mode_i(mode), .busy_i(busy), .lat_en_i(lat_en),
    .ras_o(ras), .acc_active_o(act), .alatch_o(alat)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic drive(input logic [5:0] v);
    {cs, strobe, areq, mode, busy, lat_en} = v;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst = 1'b1;
    drive(6'b000000);
    repeat (3) tick();
    // R1: reset state
    chk("R1", "ras", ras, 1'b0);
    chk("R1", "active", act, 1'b0);
    chk("R1", "alatch", alat, 1'b0);
    rst = 1'b0;
    tick();

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][8:3]);
      tick();
      chk($sformatf("vec%0d", i), "ras", ras, VEC[i][2]);
      chk($sformatf("vec%0d", i), "active", act, VEC[i][1]);
      chk($sformatf("vec%0d", i), "alatch", alat, VEC[i][0]);
    end

    // R5: mode1 combinational start, checked before any edge
    drive(6'b000100);
    tick();
    drive(6'b110110);
    #1;
    chk("R6", "ras while busy", ras, 1'b0);
    busy = 1'b0;
    #1;
    chk("R5", "ras before edge", ras, 1'b1);
    chk("R5", "active before edge", act, 1'b0);
    tick();
    chk("R5", "active after edge", act, 1'b1);
    chk("R5", "ras held", ras, 1'b1);
    areq = 1'b1; strobe = 1'b0;
    tick();
    areq = 1'b0;
    tick();
    chk("R7", "ras end", ras, 1'b0);
    chk("R7", "active end", act, 1'b0);

    // R1: reset in the middle of an access
    drive(6'b111000);
    tick();
    tick();
    chk("R3", "ras before reset", ras, 1'b1);
    rst = 1'b1;
    tick();
    chk("R1", "ras mid reset", ras, 1'b0);
    chk("R1", "active mid reset", act, 1'b0);
    rst = 1'b0;
    drive(6'b000000);
    tick();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule